// File: doc/BRIEF.md
# Two-Step Converter Timing and Control

This block sequences an 8-bit two-step (half-flash) conversion for a processor-facing data port. The analog front end is abstracted: a parallel sample word stands in for the input voltage, and the result is built in two passes. A coarse pass resolves the upper nibble. A fine pass then resolves the lower nibble from the residue that remains after the coarse code is removed. Every delay is a count of clock cycles set by a parameter.

A mode input selects one of two host protocols. In read-start mode, a falling read strobe under a low chip select begins a conversion. The shared strobe pin then acts as an open-drain ready line, which the block pulls low while the host waits. In write-start mode, the same pin carries a write strobe. A write pulse samples and converts, and the interrupt line goes low a fixed count after the write ends. The host may instead read early, once the result is complete internally, and that read latches the result at once. Holding chip select and read low in write-start mode gives stand-alone operation, where each write pulse refreshes the bus.

The controller has six states. IDLE waits for a start. TRACK follows the input while the write strobe is low. HI_FLASH and LO_FLASH run the coarse and fine passes. WAIT_INT holds a finished result in write-start mode. DONE holds the latched result with the interrupt asserted. The transitions are: IDLE or DONE to TRACK on a write-start, and IDLE or DONE to HI_FLASH on a read-start. TRACK goes to HI_FLASH when the write strobe rises. HI_FLASH goes to LO_FLASH after the coarse count. LO_FLASH goes to DONE in read-start mode, or to WAIT_INT in write-start mode. WAIT_INT goes to DONE on the interrupt count or on an early read. DONE goes to IDLE on a rise of read or chip select. INT_CYC must exceed HI_CYC + LO_CYC, and both step counts must be at least 1.

Top module: `hfadc_ctrl`

## Requirements
- R1: After reset, int_n is 1, rdy_pull_low is 0, ovf is 0 and the result latch holds 0.
- R2: The strobes cs_n, rd_n and strobe_wr_n, and the mode input, pass through a two-stage synchronizer. A level change driven between clock edges is acted on at the third rising edge after it. This is the acting edge.
- R3: data_oe equals (cs_n low AND rd_n low), combinationally from the raw pins. data_o shows the result latch while data_oe is 1 and is 0 otherwise.
- R4: In write-start mode (mode_wrrd=1), a write strobe fall with chip select low, from IDLE or DONE, clears the interrupt (int_n=1) and ovf. The sample is captured at the acting edge E of the following write strobe rise.
- R5: The result is formed in two passes: the upper nibble after HI_CYC cycles, and the lower nibble from the residue at E+HI_CYC+LO_CYC (CONV). The latched value equals the captured sample.
- R6: In write-start mode without an early read, the result is latched and int_n goes low at edge E+INT_CYC.
- R7: In write-start mode, a read fall with chip select low whose acting edge lies in (E+CONV, E+INT_CYC] latches the result and drives int_n low at that edge. A read fall acting at or before E+CONV is ignored: the bus keeps the old latch and the interrupt still comes at E+INT_CYC.
- R8: While in DONE, a rise of rd_n or cs_n sets int_n back to 1 at its acting edge.
- R9: In read-start mode (mode_wrrd=0), a read fall with chip select low captures the sample at its acting edge E. At E+CONV the result is latched and int_n goes low.
- R10: In read-start mode, rdy_pull_low becomes 1 at the acting edge of a chip-select fall. It returns to 0 at the latch edge or at a chip-select rise. It is never 1 in write-start mode.
- R11: In stand-alone use (cs_n=rd_n=0, write-start mode), each write pulse puts a new result on the bus at E+INT_CYC. int_n stays low until the next write fall clears it.
- R12: ovf is set at the latch edge when the result is all ones (0xFF), is cleared at the next start, and is 0 otherwise.
- R13: A start whose acting edge is no later than the latch edge plus GAP_CYC is ignored. The interrupt, the latch and the state are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wrrd | input | 1 | 1 selects write-start protocol, 0 selects read-start |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| strobe_wr_n | input | 1 | Shared pin sensed as write strobe in write-start mode |
| sample_i | input | 8 | Digital stand-in for the analog input |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| rdy_pull_low | output | 1 | Open-drain pull-down enable for the shared pin as ready line |
| ovf | output | 1 | Full-scale flag |
| data_oe | output | 1 | Data bus drive enable (0 means high impedance) |
| data_o | output | 8 | Data bus value |

## Verification
The bench targets the early-read window at both ends. A read falling too soon must leave the old value on the bus, and a read inside the window must interrupt at once. A design with the window edge off by one would either latch a half-built word or miss the early transfer entirely. It also restarts a write right after an interrupt in stand-alone use. A missing or short hold-off would then wrongly clear the interrupt and convert again. It also places the full-scale sample before an ordinary one, where a flag that is never cleared at the next start would stick. Ready-line timing is checked against chip-select edges in both modes, where an extra synchronizer stage or an unreleased pull-down shows up as a one-cycle slip or a line held low.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TRACK,
        S_HI_FLASH,
        S_LO_FLASH,
        S_WAIT_INT,
        S_DONE
    } hfadc_state_e;

    localparam int unsigned STROBE_W = 4;
    localparam int unsigned IDX_WR   = 0;
    localparam int unsigned IDX_RD   = 1;
    localparam int unsigned IDX_CS   = 2;
    localparam int unsigned IDX_MODE = 3;

endpackage

// File: rtl/hfadc_sync.sv
module hfadc_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] rise_o
);

    logic [STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lvl_o  = stage_q[STAGES-1];
    assign fall_o = prev_q & ~lvl_o;
    assign rise_o = ~prev_q & lvl_o;

endmodule

// File: rtl/hfadc_twostep.sv
module hfadc_twostep #(
    parameter int unsigned RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_hi_i,
    input  logic             step_lo_i,
    input  logic [RES_W-1:0] sample_i,
    output logic [RES_W-1:0] result_o
);

    localparam int unsigned HI_W = RES_W / 2;
    localparam int unsigned LO_W = RES_W - HI_W;

    logic [RES_W-1:0] held_q;
    logic [HI_W-1:0]  hi_q;
    logic [LO_W-1:0]  lo_q;
    logic [RES_W-1:0] residue;
    logic [LO_W-1:0]  lo_flash;

    // fine pass works on what the coarse code leaves behind
    assign residue  = held_q - {hi_q, {LO_W{1'b0}}};
    assign lo_flash = residue[LO_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (load_i) begin
            held_q <= sample_i;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (step_hi_i) hi_q <= held_q[RES_W-1 -: HI_W];
            if (step_lo_i) lo_q <= lo_flash;
        end
    end

    assign result_o = {hi_q, (step_lo_i ? lo_flash : lo_q)};

    p_residue_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_lo_i |-> ((residue >> LO_W) == '0));

endmodule

// File: rtl/hfadc_ctrl.sv
module hfadc_ctrl
    import hfadc_pkg::*;
#(
    parameter int unsigned RES_W   = 8,
    parameter int unsigned HI_CYC  = 3,
    parameter int unsigned LO_CYC  = 3,
    parameter int unsigned INT_CYC = 10,
    parameter int unsigned GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wrrd,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             strobe_wr_n,
    input  logic [RES_W-1:0] sample_i,
    output logic             int_n,
    output logic             rdy_pull_low,
    output logic             ovf,
    output logic             data_oe,
    output logic [RES_W-1:0] data_o
);

    localparam int unsigned CONV_CYC = HI_CYC + LO_CYC;
    localparam int unsigned CNT_W    = $clog2(INT_CYC + 2);
    localparam int unsigned GAP_W    = $clog2(GAP_CYC + 2);

    hfadc_state_e         state_q, state_d;
    logic [STROBE_W-1:0]  s_lvl, s_fall, s_rise;
    logic                 s_mode, cs_lvl;
    logic                 wr_start, rd_start, start_ok;
    logic                 load, step_hi, step_lo, latch, clr_int, clr_ovf;
    logic [CNT_W-1:0]     cnt_q;
    logic [GAP_W-1:0]     gap_q;
    logic [RES_W-1:0]     result_w, out_q;
    logic                 unused_edges;

    hfadc_sync #(
        .W      (STROBE_W),
        .STAGES (2),
        .RST_VAL(4'b0111)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({mode_wrrd, cs_n, rd_n, strobe_wr_n}),
        .lvl_o  (s_lvl),
        .fall_o (s_fall),
        .rise_o (s_rise)
    );

    assign s_mode       = s_lvl[IDX_MODE];
    assign cs_lvl       = s_lvl[IDX_CS];
    assign unused_edges = ^{s_fall[IDX_MODE], s_rise[IDX_MODE], s_lvl[IDX_RD], s_lvl[IDX_WR]};

    assign start_ok = (gap_q == '0) && !cs_lvl;
    assign wr_start = start_ok && s_mode && s_fall[IDX_WR];
    assign rd_start = start_ok && !s_mode && s_fall[IDX_RD];

    hfadc_twostep #(
        .RES_W(RES_W)
    ) u_twostep (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_hi_i(step_hi),
        .step_lo_i(step_lo),
        .sample_i (sample_i),
        .result_o (result_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions and control strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step_hi = 1'b0;
        step_lo = 1'b0;
        latch   = 1'b0;
        clr_int = 1'b0;
        clr_ovf = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (wr_start) begin
                    state_d = S_TRACK;
                    clr_int = 1'b1;
                    clr_ovf = 1'b1;
                end else if (rd_start) begin
                    state_d = S_HI_FLASH;
                    load    = 1'b1;
                    clr_int = 1'b1;
                    clr_ovf = 1'b1;
                end else if (state_q == S_DONE && (s_rise[IDX_RD] || s_rise[IDX_CS])) begin
                    state_d = S_IDLE;
                    clr_int = 1'b1;
                end
            end
            S_TRACK: begin
                if (s_rise[IDX_WR]) begin
                    state_d = S_HI_FLASH;
                    load    = 1'b1;
                end
            end
            S_HI_FLASH: begin
                if (cnt_q == CNT_W'(HI_CYC)) begin
                    state_d = S_LO_FLASH;
                    step_hi = 1'b1;
                end
            end
            S_LO_FLASH: begin
                if (cnt_q == CNT_W'(CONV_CYC)) begin
                    step_lo = 1'b1;
                    if (s_mode) begin
                        state_d = S_WAIT_INT;
                    end else begin
                        state_d = S_DONE;
                        latch   = 1'b1;
                    end
                end
            end
            S_WAIT_INT: begin
                if (cnt_q == CNT_W'(INT_CYC) || (s_fall[IDX_RD] && !cs_lvl)) begin
                    state_d = S_DONE;
                    latch   = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            gap_q        <= '0;
            int_n        <= 1'b1;
            ovf          <= 1'b0;
            out_q        <= '0;
            rdy_pull_low <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= CNT_W'(1);
            end else if (state_q inside {S_HI_FLASH, S_LO_FLASH, S_WAIT_INT}) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (latch)             gap_q <= GAP_W'(GAP_CYC);
            else if (gap_q != '0)  gap_q <= gap_q - 1'b1;

            if (latch)        int_n <= 1'b0;
            else if (clr_int) int_n <= 1'b1;

            if (latch)        ovf <= (result_w == {RES_W{1'b1}});
            else if (clr_ovf) ovf <= 1'b0;

            if (latch) out_q <= result_w;

            if (s_mode || s_rise[IDX_CS] || latch) rdy_pull_low <= 1'b0;
            else if (s_fall[IDX_CS])               rdy_pull_low <= 1'b1;
        end
    end

    assign data_oe = !cs_n && !rd_n;
    assign data_o  = data_oe ? out_q : '0;

    p_int_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> (state_q == S_DONE));

    p_ovf_clear_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_TRACK, S_HI_FLASH, S_LO_FLASH, S_WAIT_INT}) |-> !ovf);

    p_rdy_rdmode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_low |-> $past(!s_mode));

    p_lo_after_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LO_FLASH) |-> (cnt_q > CNT_W'(HI_CYC)));

    p_bus_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe) && !$past(latch)) |-> $stable(data_o));

endmodule

// File: tb/hfadc_ctrl_tb.sv
`timescale 1ns/1ps
module hfadc_ctrl_tb;

    localparam int HI = 3, LO = 3, INTC = 10, GAP = 4;
    localparam int CONV = HI + LO;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] sample = 8'h00;
    logic int_n, rdy_pull_low, ovf, data_oe;
    logic [7:0] data_o;

    int n_chk = 0, n_fail = 0;
    bit fin = 1'b0;
    string cur = "R1";

    always #4 clk = ~clk;

    hfadc_ctrl #(.RES_W(8), .HI_CYC(HI), .LO_CYC(LO), .INT_CYC(INTC), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wrrd(mode), .cs_n(cs_n), .rd_n(rd_n),
        .strobe_wr_n(wr_n), .sample_i(sample), .int_n(int_n), .rdy_pull_low(rdy_pull_low),
        .ovf(ovf), .data_oe(data_oe), .data_o(data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference: edge index bookkeeping per requirement
    int  idx, st_edge, lat_edge, mph;
    logic [7:0] m_held, m_out;
    logic m_int, m_rdy, m_ovf;
    logic [3:0] q0, q1, q2; // {mode, cs, rd, wr}

    always @(posedge clk) begin : ref_model
        bit md, csl, csf, csr, rdf, rdr, wrf, wrr, lat, can;
        if (!rst_n) begin
            mph = 0; m_int = 1; m_rdy = 0; m_ovf = 0; m_out = 0; m_held = 0;
            q0 = 4'b0111; q1 = 4'b0111; q2 = 4'b0111;
            idx = 0; st_edge = 0; lat_edge = -1000;
        end else begin
            idx++;
            md  = q1[3]; csl = q1[2];
            csf = q2[2] & ~q1[2]; csr = ~q2[2] & q1[2];
            rdf = q2[1] & ~q1[1]; rdr = ~q2[1] & q1[1];
            wrf = q2[0] & ~q1[0]; wrr = ~q2[0] & q1[0];
            lat = 0;
            can = (idx > lat_edge + GAP) && !csl;
            if (mph == 0 || mph == 4) begin
                if (can && md && wrf) begin
                    mph = 1; m_int = 1; m_ovf = 0;
                end else if (can && !md && rdf) begin
                    mph = 2; st_edge = idx; m_held = sample; m_int = 1; m_ovf = 0;
                end else if (mph == 4 && (rdr || csr)) begin
                    mph = 0; m_int = 1;
                end
            end else if (mph == 1) begin
                if (wrr) begin mph = 2; st_edge = idx; m_held = sample; end
            end else begin
                if (!md) begin
                    if (idx == st_edge + CONV) lat = 1;
                end else if (idx == st_edge + INTC || (idx > st_edge + CONV && rdf && !csl)) begin
                    lat = 1;
                end
            end
            if (lat) begin
                m_out = m_held; m_ovf = (m_held == 8'hFF); m_int = 0; mph = 4; lat_edge = idx;
            end
            if (md || csr || lat) m_rdy = 0;
            else if (csf)         m_rdy = 1;
            q2 = q1; q1 = q0; q0 = {mode, cs_n, rd_n, wr_n};
        end
    end

    always begin
        @(posedge clk);
        #2;
        if (rst_n && !fin) begin
            logic m_oe;
            m_oe = !cs_n && !rd_n;
            chk({cur, " R2 cycle compare"},
                {19'd0, int_n, rdy_pull_low, ovf, data_oe, data_o},
                {19'd0, m_int, m_rdy, m_ovf, m_oe, (m_oe ? m_out : 8'h00)});
        end
    end

    task automatic wr_pulse(input logic [7:0] v);
        sample = v; wr_n = 1'b0; cyc(3); wr_n = 1'b1;
    endtask

    initial begin : main
        cyc(4);
        chk("R1 int_n", {31'd0, int_n}, 1);
        chk("R1 rdy/ovf/latch", {22'd0, rdy_pull_low, ovf, data_o}, 0);
        rst_n = 1'b1;
        cyc(4);

        cur = "R6"; cs_n = 1'b0; cyc(2);
        wr_pulse(8'hA5);
        cyc(2 + INTC); chk("R6 int before delay", {31'd0, int_n}, 1);
        cyc(1);        chk("R6 int at delay", {31'd0, int_n}, 0);
        rd_n = 1'b0; cyc(1);
        chk("R5 R4 result equals sample", {23'd0, data_oe, data_o}, {23'd0, 1'b1, 8'hA5});
        cur = "R8"; rd_n = 1'b1; cyc(2);
        chk("R8 int held", {31'd0, int_n}, 0);
        cyc(1); chk("R8 rd rise clears", {31'd0, int_n}, 1);
        cyc(4);
        wr_pulse(8'h5A);
        cyc(3 + INTC); chk("R6 second int", {31'd0, int_n}, 0);
        cs_n = 1'b1; cyc(3); chk("R8 cs rise clears", {31'd0, int_n}, 1);
        cur = "R3"; cs_n = 1'b0; #1;
        chk("R3 rd high no drive", {23'd0, data_oe, data_o}, 0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R3 cs high no drive", {23'd0, data_oe, data_o}, 0);
        rd_n = 1'b1; cs_n = 1'b0; cyc(6);

        cur = "R7"; wr_pulse(8'h3C);
        cyc(8); rd_n = 1'b0;
        cyc(2); chk("R7 early read not yet", {31'd0, int_n}, 1);
        cyc(1); chk("R7 early read latches", {23'd0, int_n, data_o}, {23'd0, 1'b0, 8'h3C});
        rd_n = 1'b1; cyc(6);
        wr_pulse(8'hC3);
        cyc(4); rd_n = 1'b0;
        cyc(1); chk("R7 too-early read keeps old", {24'd0, data_o}, 8'h3C);
        cyc(2 + INTC - 5); chk("R7 too-early no int", {31'd0, int_n}, 1);
        cyc(1); chk("R7 normal int after ignore", {23'd0, int_n, data_o}, {23'd0, 1'b0, 8'hC3});
        rd_n = 1'b1; cs_n = 1'b1; cyc(6);

        cur = "R9"; mode = 1'b0; cyc(4);
        cs_n = 1'b0; cyc(2); chk("R2 R10 rdy not yet", {31'd0, rdy_pull_low}, 0);
        cyc(1); chk("R10 rdy pulled", {31'd0, rdy_pull_low}, 1);
        sample = 8'hFF; rd_n = 1'b0;
        cyc(2 + CONV); chk("R9 busy", {30'd0, int_n, rdy_pull_low}, {30'd0, 1'b1, 1'b1});
        cyc(1); chk("R9 R10 done", {22'd0, int_n, rdy_pull_low, data_o}, {22'd0, 1'b0, 1'b0, 8'hFF});
        chk("R12 full scale", {31'd0, ovf}, 1);
        rd_n = 1'b1; cyc(4); chk("R8 rd-mode clear", {31'd0, int_n}, 1);
        sample = 8'h42; rd_n = 1'b0;
        cyc(3); chk("R12 cleared at start", {31'd0, ovf}, 0);
        cyc(CONV); chk("R9 second result", {23'd0, int_n, data_o}, {23'd0, 1'b0, 8'h42});
        chk("R12 not full", {31'd0, ovf}, 0);
        rd_n = 1'b1; cyc(4);
        cs_n = 1'b1; cyc(4); cs_n = 1'b0; cyc(3);
        chk("R10 pulled again", {31'd0, rdy_pull_low}, 1);
        cs_n = 1'b1; cyc(3); chk("R10 released on cs rise", {31'd0, rdy_pull_low}, 0);
        mode = 1'b1; cyc(4); cs_n = 1'b0; cyc(4);
        chk("R10 never in write mode", {31'd0, rdy_pull_low}, 0);

        cur = "R11"; rd_n = 1'b0; cyc(4);
        wr_pulse(8'h12);
        for (int g = 0; g < 100 && int_n === 1'b1; g++) @(negedge clk);
        chk("R11 stand-alone result", {23'd0, int_n, data_o}, {23'd0, 1'b0, 8'h12});
        cur = "R13"; wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(6);
        chk("R13 start in hold-off ignored", {23'd0, int_n, data_o}, {23'd0, 1'b0, 8'h12});
        cur = "R11"; cyc(4);
        sample = 8'h99; wr_n = 1'b0;
        cyc(3); chk("R11 write fall clears int", {31'd0, int_n}, 1);
        wr_n = 1'b1;
        cyc(2 + INTC); chk("R11 not yet", {24'd0, data_o}, 8'h12);
        cyc(1); chk("R11 new result on bus", {23'd0, int_n, data_o}, {23'd0, 1'b0, 8'h99});
        cyc(4);

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 8);
        if (!fin) begin
            fin = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL %s watchdog actual=timeout expected=finish", cur);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule